// File: doc/BRIEF.md
# Bitmap Contiguous-Run Placement Allocator

This block manages a pool of equal-sized allocation units. It keeps one occupancy bit per unit, and a set bit means the unit is taken. An allocation request asks for a number of adjacent units. The block walks the occupancy map one unit per clock and measures every free run it meets. It then chooses a run according to a placement rule picked with each request: lowest address, tightest fit or loosest fit. It marks the chosen units as taken and returns the index of the first unit. A release request clears a given range of units in a single cycle.

A request is accepted when `req_valid` is high and `busy` is low. The answer is a one-cycle `rsp_done` pulse. `rsp_fail` qualifies the pulse. When the pulse belongs to a successful allocation, `rsp_start` carries the index of the first unit. The whole occupancy map is visible on `map_out`. An allocation that finds no single free run long enough fails, even when the total free space would be enough.

Top module: `bitmap_placer`

## Requirements
- R1: After reset, `map_out` is all zero, `busy` is low and `rsp_done` is low.
- R2: When `req_free`=0, the request is an allocation. A successful allocation sets exactly the bits [`rsp_start`, `rsp_start`+`req_len`-1] of `map_out`, all of which were zero before. No other bit changes. `rsp_done`=1 and `rsp_fail`=0 are reported in the same cycle.
- R3: Policy code 0 (and code 3) selects first-fit. The chosen run is the lowest-addressed free run with length ≥ `req_len`.
- R4: Policy code 1 selects best-fit. The chosen run is the shortest free run with length ≥ `req_len`. When two runs tie, the lower-addressed one is chosen.
- R5: Policy code 2 selects worst-fit. The chosen run is the longest free run; when two runs tie, the lower-addressed one is chosen. If that run is shorter than `req_len`, the allocation fails.
- R6: If no single free run is at least `req_len` long, the allocation fails with `rsp_done`=1 and `rsp_fail`=1, and `map_out` is left unchanged. This holds even when the total number of free units would be enough.
- R7: An allocation with `req_len`=0 or `req_len` > UNITS fails in the cycle after it is accepted, and `map_out` is left unchanged.
- R8: When `req_free`=1, the request is a release. A valid release clears bits [`req_start`, `req_start`+`req_len`-1]. The result appears in the cycle after acceptance, together with `rsp_done`=1 and `rsp_fail`=0.
- R9: A release fails, and `map_out` is left unchanged, in any of these cases: the range holds a unit that is already free, `req_len`=0, or `req_start`+`req_len` > UNITS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; accepted when `busy` is low |
| req_free | input | 1 | 0 = allocate, 1 = release |
| req_policy | input | 2 | Placement rule: 0 first-fit, 1 best-fit, 2 worst-fit, 3 first-fit |
| req_len | input | $clog2(UNITS+1) | Number of units |
| req_start | input | $clog2(UNITS) | First unit of a release |
| busy | output | 1 | Allocation scan in progress |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_fail | output | 1 | Request failed (valid with `rsp_done`) |
| rsp_start | output | $clog2(UNITS) | First unit of the granted run |
| map_out | output | UNITS | Occupancy map, bit i = unit i in use |

## Verification
The placement rules are tried on a hand-built map that holds free runs of lengths 3, 5, 3 and 8. Asking for three units separates the rules: best-fit must return the earlier of the two tied length-3 runs, worst-fit the length-8 run, and first-fit the first run that fits. The same map, asked for nine units, shows that the block fails on fragmentation even though 19 units are free. Degenerate lengths, out-of-range releases and double releases check that a rejected request leaves the map unchanged. A long random mix of allocations and releases then drives all three rules over maps with many run layouts, and each result is compared with a bench model that scans the runs on its own.

// File: rtl/bitmap_placer.sv
module bitmap_placer #(
  parameter int UNITS = 32,
  localparam int IW = $clog2(UNITS),
  localparam int LW = $clog2(UNITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_free,
  input  logic [1:0]       req_policy,
  input  logic [LW-1:0]    req_len,
  input  logic [IW-1:0]    req_start,
  output logic             busy,
  output logic             rsp_done,
  output logic             rsp_fail,
  output logic [IW-1:0]    rsp_start,
  output logic [UNITS-1:0] map_out
);

  localparam logic [1:0] POL_BEST  = 2'd1;
  localparam logic [1:0] POL_WORST = 2'd2;

  logic [UNITS-1:0] map_q;
  logic             scanning;
  logic [IW-1:0]    idx;
  logic [1:0]       pol_q;
  logic [LW-1:0]    len_q, run_len, best_len;
  logic [IW-1:0]    run_start, best_start;
  logic             have;

  function automatic logic [UNITS-1:0] span(input int s, input int n);
    logic [UNITS-1:0] m;
    for (int i = 0; i < UNITS; i++) m[i] = (i >= s) && (i < s + n);
    return m;
  endfunction

  logic             bit_free, last, run_end, take, nhave, range_ok;
  logic [LW-1:0]    cur_len;
  logic [IW-1:0]    cur_start, nstart;
  logic [UNITS-1:0] fmask;

  assign bit_free  = !map_q[idx];
  assign last      = (int'(idx) == UNITS - 1);
  assign run_end   = !bit_free || last;
  assign cur_len   = bit_free ? run_len + LW'(1) : run_len;
  assign cur_start = (bit_free && run_len == '0) ? idx : run_start;
  assign take      = run_end && (cur_len >= len_q) &&
                     (!have || (pol_q == POL_BEST  && cur_len < best_len)
                            || (pol_q == POL_WORST && cur_len > best_len));
  assign nhave     = have | take;
  assign nstart    = take ? cur_start : best_start;

  assign range_ok  = (req_len != '0) && (int'(req_start) + int'(req_len) <= UNITS);
  assign fmask     = span(int'(req_start), int'(req_len));

  assign busy    = scanning;
  assign map_out = map_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      map_q      <= '0;
      scanning   <= 1'b0;
      idx        <= '0;
      pol_q      <= '0;
      len_q      <= '0;
      run_len    <= '0;
      run_start  <= '0;
      best_len   <= '0;
      best_start <= '0;
      have       <= 1'b0;
      rsp_done   <= 1'b0;
      rsp_fail   <= 1'b0;
      rsp_start  <= '0;
    end else begin
      rsp_done <= 1'b0;
      rsp_fail <= 1'b0;
      if (!scanning && req_valid) begin
        if (req_free) begin
          rsp_done  <= 1'b1;
          rsp_start <= req_start;
          if (!range_ok || (map_q & fmask) != fmask) rsp_fail <= 1'b1;
          else map_q <= map_q & ~fmask;
        end else if (req_len == '0 || int'(req_len) > UNITS) begin
          rsp_done <= 1'b1;
          rsp_fail <= 1'b1;
        end else begin
          scanning  <= 1'b1;
          idx       <= '0;
          run_len   <= '0;
          run_start <= '0;
          best_len  <= '0;
          have      <= 1'b0;
          pol_q     <= req_policy;
          len_q     <= req_len;
        end
      end else if (scanning) begin
        run_len    <= bit_free ? cur_len : '0;
        run_start  <= cur_start;
        have       <= nhave;
        best_start <= nstart;
        best_len   <= take ? cur_len : best_len;
        idx        <= idx + IW'(1);
        if (last) begin
          scanning  <= 1'b0;
          rsp_done  <= 1'b1;
          rsp_fail  <= !nhave;
          rsp_start <= nstart;
          if (nhave) map_q <= map_q | span(int'(nstart), int'(len_q));
        end
      end
    end
  end

endmodule

module bitmap_placer_chk #(
  parameter int UNITS = 32,
  localparam int IW = $clog2(UNITS),
  localparam int LW = $clog2(UNITS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_free,
  input logic [LW-1:0]    req_len,
  input logic             busy,
  input logic             rsp_done,
  input logic             rsp_fail,
  input logic [IW-1:0]    rsp_start,
  input logic [UNITS-1:0] map_out
);

  logic          op_free_q;
  logic [LW-1:0] op_len_q;
  logic [UNITS-1:0] gmask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_free_q <= 1'b0;
      op_len_q  <= '0;
    end else if (req_valid && !busy) begin
      op_free_q <= req_free;
      op_len_q  <= req_len;
    end
  end

  always_comb
    for (int i = 0; i < UNITS; i++)
      gmask[i] = (i >= int'(rsp_start)) && (i < int'(rsp_start) + int'(op_len_q));

  assert_reset_clear_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (map_out == '0 && !rsp_done));

  assert_grant_span_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && !rsp_fail && !op_free_q) |->
      (($past(map_out) & gmask) == '0 && map_out == ($past(map_out) | gmask)));

  assert_fail_keeps_map_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_fail) |-> $stable(map_out));

  assert_bad_len_fast_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && !req_free && (req_len == '0 || int'(req_len) > UNITS))
      |=> (rsp_done && rsp_fail));

  assert_release_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && !rsp_fail && op_free_q) |->
      ($countones(map_out) + int'(op_len_q) == $countones($past(map_out))));

  assert_map_quiet_in_scan_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(map_out) || rsp_done));

  assert_fail_only_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fail |-> rsp_done);

endmodule

bind bitmap_placer bitmap_placer_chk #(.UNITS(UNITS)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_free(req_free),
  .req_len(req_len), .busy(busy), .rsp_done(rsp_done), .rsp_fail(rsp_fail),
  .rsp_start(rsp_start), .map_out(map_out)
);

// File: tb/bitmap_placer_tb.sv
module bitmap_placer_tb_top;
  localparam int UNITS = 32;
  localparam int IW = $clog2(UNITS);
  localparam int LW = $clog2(UNITS + 1);
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_free = 1'b0;
  logic [1:0] req_policy = '0;
  logic [LW-1:0] req_len = '0;
  logic [IW-1:0] req_start = '0;
  logic busy, rsp_done, rsp_fail;
  logic [IW-1:0] rsp_start;
  logic [UNITS-1:0] map_out;

  bitmap_placer #(.UNITS(UNITS)) dut_i (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, miscompares = 0, cyc = 0;
  bit ended = 0;
  logic [UNITS-1:0] mdl = '0;

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      miscompares++;
      $display("FAIL watchdog: run hung, got cycle %0d expected < 150000", cyc);
      finish_run();
    end
  end

  task automatic check(input string tag, input longint act, input longint exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit model_alloc(input int pol, input int len, output int st);
    int rs = 0, rl = 0, bl = 0;
    bit have = 0;
    st = 0;
    if (len == 0 || len > UNITS) return 0;
    for (int i = 0; i <= UNITS; i++) begin
      if (i < UNITS && !mdl[i]) begin
        if (rl == 0) rs = i;
        rl++;
      end else begin
        if (rl >= len && (!have || (pol == 1 && rl < bl) || (pol == 2 && rl > bl))) begin
          have = 1; bl = rl; st = rs;
        end
        rl = 0;
      end
    end
    return have;
  endfunction

  task automatic issue(input bit fr, input int pol, input int len, input int st);
    int w = 0;
    @(negedge clk);
    req_valid = 1'b1; req_free = fr; req_policy = 2'(pol);
    req_len = LW'(len); req_start = IW'(st);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_done && w < 100) begin @(negedge clk); w++; end
  endtask

  task automatic do_alloc(input int pol, input int len, input string tag);
    int est; bit ok;
    ok = model_alloc(pol, len, est);
    issue(0, pol, len, 0);
    check({tag, " done"}, rsp_done, 1);
    check({tag, " fail"}, rsp_fail, !ok);
    if (ok) begin
      check({tag, " start"}, rsp_start, est);
      for (int i = est; i < est + len; i++) mdl[i] = 1'b1;
    end
    check({tag, " map"}, map_out, mdl);
  endtask

  task automatic do_free(input int st, input int len, input string tag);
    bit ok;
    ok = (len != 0) && (st + len <= UNITS);
    if (ok) for (int i = st; i < st + len; i++) if (!mdl[i]) ok = 0;
    issue(1, 0, len, st);
    check({tag, " done"}, rsp_done, 1);
    check({tag, " fail"}, rsp_fail, !ok);
    if (ok) for (int i = st; i < st + len; i++) mdl[i] = 1'b0;
    check({tag, " map"}, map_out, mdl);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 map", map_out, 0);
    check("R1 busy", busy, 0);
    check("R1 done", rsp_done, 0);

    do_alloc(0, 0, "R7 zero len");
    do_alloc(1, UNITS + 1, "R7 oversize");
    do_free(0, 1, "R9 free of free unit");
    do_alloc(0, UNITS, "R2 full");
    do_free(30, 5, "R9 out of range");
    do_free(3, 0, "R9 zero len");
    do_free(2, 3, "R8 release a");
    do_free(8, 5, "R8 release b");
    do_free(16, 3, "R8 release c");
    do_free(24, 8, "R8 release d");
    do_free(3, 2, "R9 double release");
    do_alloc(2, 9, "R5 largest too short");
    do_alloc(0, 9, "R6 fragmented");
    do_alloc(1, 9, "R6 fragmented best");
    do_alloc(1, 3, "R4 tie lower");
    do_alloc(2, 3, "R5 worst pick");
    do_alloc(0, 4, "R3 first fit");
    do_alloc(3, 1, "R3 code three");

    for (int n = 0; n < 400; n++) begin
      int k = int'($urandom_range(0, 9));
      if (k < 5)
        do_alloc(int'($urandom_range(0, 3)), int'($urandom_range(1, 10)), "R2 random alloc");
      else
        do_free(int'($urandom_range(0, UNITS - 1)), int'($urandom_range(1, 6)), "R8 random free");
    end
    finish_run();
  end
endmodule